// File: doc/BRIEF.md
# SCSI Data FIFO with Byte and Halfword DMA Ports

This block is the byte FIFO that sits between the host side of a SCSI controller and its bus engine. It holds up to 16 bytes. An 8-bit port pushes and pops single bytes. A 16-bit port moves two bytes per access, least significant byte first. A transfer counter tracks the bytes moved, and a DMA request level tells the DMA engine when to act. The halfword port falls back to a single byte when the FIFO is nearly full, nearly empty, or when only one byte of the transfer is left. For device-to-memory transfers the request can be held back so that a final odd byte stays in the FIFO for the processor to collect.

All accesses are single-cycle strobes. The port has no valid/ready pair and no back-pressure: the DMA engine paces itself from `drq`, and a strobe that cannot be served is dropped or degraded as the requirements state. At most one operation is accepted per cycle. Read data is registered and appears on `rdata` in the cycle after the read strobe. The `SWAP_BYTES` parameter builds a variant for big-endian hosts that exchanges the two bytes of every halfword on both read and write.

Top module: `scsi_fifo16`

## Requirements
- R1: After reset, `fifo_count`, `drq`, `term_count` and `rdata` are all zero.
- R2: `byte_wr` appends `byte_wdata` to the FIFO. `byte_rd` removes the oldest byte and shows it as `{8'h00, byte}` on `rdata` one cycle later. A byte write to a full FIFO (16 bytes) changes nothing. A byte read from an empty FIFO loads `rdata` with 0 and changes nothing else.
- R3: `half_rd` with 2 or more bytes stored removes two bytes. The older byte goes to `rdata[7:0]` and the newer byte to `rdata[15:8]`.
- R4: `half_rd` with exactly one byte stored removes it and returns `{8'hFF, byte}`. On an empty FIFO it returns 16'hFF00 and changes nothing.
- R5: `half_wr` stores `half_wdata[7:0]` first and `half_wdata[15:8]` second, and lowers the transfer counter by 2.
- R6: `half_wr` stores only `half_wdata[7:0]` and lowers the counter by 1 when the FIFO holds more than 14 bytes or the counter equals 1. If the FIFO is full, it changes nothing.
- R7: `cnt_load` loads the counter with `cnt_value` and clears `term_count`. Each byte write lowers the counter by 1. Reads lower it by the number of bytes removed only when `sync_offset` is nonzero. The counter saturates at zero.
- R8: `term_count` sets on the first decrement that leaves the counter at zero. It stays set until the next `cnt_load`.
- R9: When `dma_en`=1 and `dma_to_mem`=1, `drq` is high when `fifo_count` exceeds 1 (if `save_residual`=1) or exceeds 0 (if `save_residual`=0). When `sync_offset` is nonzero, `term_count` must also be clear.
- R10: When `dma_en`=1 and `dma_to_mem`=0, `drq` is high when `term_count` is clear and the FIFO is not full. When `dma_en`=0, `drq` is low.
- R11: With `SWAP_BYTES`=1, the halfword write stores `half_wdata[15:8]` first, and the halfword read returns the older byte in bits 15:8. A read with one byte stored returns `{byte, 8'hFF}`, and an empty read returns 16'h00FF.
- R12: `peek_rd` loads `rdata` with `{8'h00, oldest byte}` (0 when the FIFO is empty). It leaves the FIFO, the counter, `term_count` and `drq` untouched.
- R13: Only one operation is taken per cycle. The priority is `cnt_load`, then `half_wr`, `byte_wr`, `half_rd`, `byte_rd`, `peek_rd`. Any other strobe in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_load | input | 1 | Load transfer counter |
| cnt_value | input | CW | Value for counter load |
| dma_en | input | 1 | DMA transfer active |
| dma_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| sync_offset | input | SOW | Synchronous offset, 0 = asynchronous |
| save_residual | input | 1 | Keep the last odd byte for the processor |
| byte_wr | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| byte_rd | input | 1 | Byte read strobe |
| half_wr | input | 1 | Halfword write strobe |
| half_wdata | input | 16 | Halfword write data |
| half_rd | input | 1 | Halfword read strobe |
| peek_rd | input | 1 | Non-destructive head read |
| rdata | output | 16 | Registered read data |
| drq | output | 1 | DMA request level |
| fifo_count | output | $clog2(DEPTH)+1 | Bytes held |
| term_count | output | 1 | Transfer counter reached zero |

## Verification
The bench targets three kinds of boundary. The first is the halfword port at 15 and 16 bytes stored and at a counter of 1; a design that ignored these would overrun the FIFO or let the counter skip past zero without flagging it. The second is halfword reads with one or zero bytes left; a wrong design would underflow or return stale upper bytes instead of the 0xFF fill. The third is the request level with the residual bit and with synchronous offset after terminal count; errors there show up as a request that drains the last byte or one that keeps firing after the transfer has ended. A byte-swapped instance runs the same stimulus, and a peek done between operations must leave the count and flags unchanged.

// File: rtl/scsi_fifo16_pkg.sv
package scsi_fifo16_pkg;
  // one accepted operation per cycle, listed in priority order
  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_HWR, OP_BWR, OP_HRD, OP_BRD, OP_PEEK
  } sf_op_e;
endpackage

// File: rtl/sf16_store.sv
module sf16_store #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 push_n,
  input  logic [15:0]                push_w,
  input  logic [1:0]                 pop_n,
  output logic [7:0]                 head0,
  output logic [7:0]                 head1,
  output logic [$clog2(DEPTH):0]     occ
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW-1:0] wp1, rp1;

  assign wp1   = wp + AW'(1);
  assign rp1   = rp + AW'(1);
  assign head0 = mem[rp];
  assign head1 = mem[rp1];

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp]  <= push_w[7:0];
    if (push_n == 2'd2) mem[wp1] <= push_w[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      wp  <= wp + AW'(push_n);
      rp  <= rp + AW'(pop_n);
      occ <= occ + NW'(push_n) - NW'(pop_n);
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= NW'(DEPTH));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    NW'(pop_n) <= occ);
endmodule

// File: rtl/sf16_xcount.sv
module sf16_xcount #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [1:0]    dec_n,
  output logic          tc,
  output logic          is_one
);
  logic [CW-1:0] cnt, cnt_nxt;

  assign cnt_nxt = (cnt > CW'(dec_n)) ? cnt - CW'(dec_n) : '0;
  assign is_one  = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tc  <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      tc  <= 1'b0;
    end else if (dec_n != 2'd0) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == '0) tc <= 1'b1;
    end
  end

  p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc && !load |=> tc);
  p_tc_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> cnt == '0);
endmodule

// File: rtl/sf16_drq.sv
module sf16_drq #(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dma_en,
  input  logic                   to_mem,
  input  logic                   sync_nz,
  input  logic                   save_res,
  input  logic                   tc,
  input  logic [$clog2(DEPTH):0] occ,
  output logic                   drq
);
  localparam int NW = $clog2(DEPTH) + 1;
  logic [NW-1:0] floor_lvl;

  assign floor_lvl = save_res ? NW'(1) : NW'(0);

  always_comb begin
    drq = 1'b0;
    if (dma_en) begin
      if (to_mem) drq = (occ > floor_lvl) && !(sync_nz && tc);
      else        drq = !tc && (occ < NW'(DEPTH));
    end
  end

  p_drq_stop_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tc && sync_nz && to_mem |-> !drq);
endmodule

// File: rtl/scsi_fifo16.sv
module scsi_fifo16
  import scsi_fifo16_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CW         = 16,
  parameter int SOW        = 5,
  parameter bit SWAP_BYTES = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_load,
  input  logic [CW-1:0]          cnt_value,
  input  logic                   dma_en,
  input  logic                   dma_to_mem,
  input  logic [SOW-1:0]         sync_offset,
  input  logic                   save_residual,
  input  logic                   byte_wr,
  input  logic [7:0]             byte_wdata,
  input  logic                   byte_rd,
  input  logic                   half_wr,
  input  logic [15:0]            half_wdata,
  input  logic                   half_rd,
  input  logic                   peek_rd,
  output logic [15:0]            rdata,
  output logic                   drq,
  output logic [$clog2(DEPTH):0] fifo_count,
  output logic                   term_count
);
  localparam int NW = $clog2(DEPTH) + 1;

  sf_op_e        op;
  logic [7:0]    h0, h1;
  logic          cnt_one, sync_nz;
  logic [1:0]    push_n, pop_n, dec_n;
  logic [15:0]   push_w, rd_nxt;
  logic          rd_ld;
  logic [15:0]   wr_word, half_raw, half_out;

  assign sync_nz = (sync_offset != '0);

  generate
    if (SWAP_BYTES) begin : g_swap
      assign wr_word  = {half_wdata[7:0], half_wdata[15:8]};
      assign half_out = {half_raw[7:0], half_raw[15:8]};
    end else begin : g_direct
      assign wr_word  = half_wdata;
      assign half_out = half_raw;
    end
  endgenerate

  always_comb begin
    if (cnt_load)     op = OP_LOAD;
    else if (half_wr) op = OP_HWR;
    else if (byte_wr) op = OP_BWR;
    else if (half_rd) op = OP_HRD;
    else if (byte_rd) op = OP_BRD;
    else if (peek_rd) op = OP_PEEK;
    else              op = OP_NONE;
  end

  always_comb begin
    if (fifo_count >= NW'(2))      half_raw = {h1, h0};
    else if (fifo_count == NW'(1)) half_raw = {8'hFF, h0};
    else                           half_raw = 16'hFF00;
  end

  always_comb begin
    push_n = 2'd0;
    pop_n  = 2'd0;
    dec_n  = 2'd0;
    push_w = 16'h0000;
    rd_ld  = 1'b0;
    rd_nxt = 16'h0000;
    unique case (op)
      OP_HWR: begin
        if (fifo_count >= NW'(DEPTH - 1) || cnt_one) begin
          if (fifo_count != NW'(DEPTH)) begin
            push_n = 2'd1;
            push_w = {8'h00, wr_word[7:0]};
            dec_n  = 2'd1;
          end
        end else begin
          push_n = 2'd2;
          push_w = wr_word;
          dec_n  = 2'd2;
        end
      end
      OP_BWR: begin
        if (fifo_count != NW'(DEPTH)) begin
          push_n = 2'd1;
          push_w = {8'h00, byte_wdata};
          dec_n  = 2'd1;
        end
      end
      OP_HRD: begin
        rd_ld  = 1'b1;
        rd_nxt = half_out;
        if (fifo_count >= NW'(2))      pop_n = 2'd2;
        else if (fifo_count == NW'(1)) pop_n = 2'd1;
        dec_n = sync_nz ? pop_n : 2'd0;
      end
      OP_BRD: begin
        rd_ld = 1'b1;
        if (fifo_count != '0) begin
          rd_nxt = {8'h00, h0};
          pop_n  = 2'd1;
          dec_n  = sync_nz ? 2'd1 : 2'd0;
        end
      end
      OP_PEEK: begin
        rd_ld = 1'b1;
        if (fifo_count != '0) rd_nxt = {8'h00, h0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= 16'h0000;
    else if (rd_ld) rdata <= rd_nxt;
  end

  sf16_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_w(push_w),
    .pop_n(pop_n), .head0(h0), .head1(h1), .occ(fifo_count)
  );

  sf16_xcount #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .load(op == OP_LOAD), .load_val(cnt_value),
    .dec_n(dec_n), .tc(term_count), .is_one(cnt_one)
  );

  sf16_drq #(.DEPTH(DEPTH)) u_drq (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .to_mem(dma_to_mem),
    .sync_nz(sync_nz), .save_res(save_residual), .tc(term_count),
    .occ(fifo_count), .drq(drq)
  );

  p_full_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HWR || op == OP_BWR) && fifo_count == NW'(DEPTH)
    |=> $stable(fifo_count));
  p_half_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HWR && fifo_count < NW'(DEPTH - 1) && !cnt_one
    |=> fifo_count == $past(fifo_count) + NW'(2));
  p_peek_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PEEK |=> $stable(fifo_count) && $stable(term_count));
endmodule

// File: tb/scsi_fifo16_bench.sv
`timescale 1ns/1ps
module scsi_fifo16_bench;
  localparam int DEPTH = 16;
  localparam int CW    = 16;
  localparam int SOW   = 5;
  localparam int NW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cnt_load = 0, dma_en = 0, dma_to_mem = 0, save_residual = 0;
  logic [CW-1:0] cnt_value = '0;
  logic [SOW-1:0] sync_offset = '0;
  logic byte_wr = 0, byte_rd = 0, half_wr = 0, half_rd = 0, peek_rd = 0;
  logic [7:0] byte_wdata = '0;
  logic [15:0] half_wdata = '0;

  logic [15:0] rd_a, rd_b;
  logic drq_a, drq_b, tc_a, tc_b;
  logic [NW-1:0] cnt_a, cnt_b;

  scsi_fifo16 #(.DEPTH(DEPTH), .CW(CW), .SOW(SOW), .SWAP_BYTES(1'b0)) u_scsi_fifo16 (
    .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .dma_en(dma_en), .dma_to_mem(dma_to_mem), .sync_offset(sync_offset),
    .save_residual(save_residual), .byte_wr(byte_wr), .byte_wdata(byte_wdata),
    .byte_rd(byte_rd), .half_wr(half_wr), .half_wdata(half_wdata),
    .half_rd(half_rd), .peek_rd(peek_rd), .rdata(rd_a), .drq(drq_a),
    .fifo_count(cnt_a), .term_count(tc_a));

  scsi_fifo16 #(.DEPTH(DEPTH), .CW(CW), .SOW(SOW), .SWAP_BYTES(1'b1)) u_swap (
    .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .dma_en(dma_en), .dma_to_mem(dma_to_mem), .sync_offset(sync_offset),
    .save_residual(save_residual), .byte_wr(byte_wr), .byte_wdata(byte_wdata),
    .byte_rd(byte_rd), .half_wr(half_wr), .half_wdata(half_wdata),
    .half_rd(half_rd), .peek_rd(peek_rd), .rdata(rd_b), .drq(drq_b),
    .fifo_count(cnt_b), .term_count(tc_b));

  int checks = 0;
  int fails  = 0;

  logic [7:0] q0[$];
  logic [7:0] q1[$];
  int unsigned m_cnt0 = 0, m_cnt1 = 0;
  bit m_tc0 = 0, m_tc1 = 0;
  logic [15:0] m_rd0 = '0, m_rd1 = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit drq_model(int sz, bit tc);
    if (!dma_en) return 1'b0;
    if (dma_to_mem)
      return (sz > (save_residual ? 1 : 0)) && !((sync_offset != 0) && tc);
    return !tc && (sz < DEPTH);
  endfunction

  // behavioural reference: one accepted operation per clock
  task automatic mstep(ref logic [7:0] q[$], ref int unsigned cnt, ref bit tc,
                       ref logic [15:0] rd, input bit sw);
    int dec = 0;
    logic [15:0] w, v;
    logic [7:0] a, b;
    bit sy = (sync_offset != 0);
    w = sw ? {half_wdata[7:0], half_wdata[15:8]} : half_wdata;
    if (cnt_load) begin
      cnt = cnt_value;
      tc  = 0;
    end else if (half_wr) begin
      if (q.size() > DEPTH - 2 || cnt == 1) begin
        if (q.size() < DEPTH) begin q.push_back(w[7:0]); dec = 1; end
      end else begin
        q.push_back(w[7:0]); q.push_back(w[15:8]); dec = 2;
      end
    end else if (byte_wr) begin
      if (q.size() < DEPTH) begin q.push_back(byte_wdata); dec = 1; end
    end else if (half_rd) begin
      if (q.size() >= 2) begin
        a = q.pop_front(); b = q.pop_front(); v = {b, a}; dec = sy ? 2 : 0;
      end else if (q.size() == 1) begin
        a = q.pop_front(); v = {8'hFF, a}; dec = sy ? 1 : 0;
      end else v = 16'hFF00;
      rd = sw ? {v[7:0], v[15:8]} : v;
    end else if (byte_rd) begin
      if (q.size() > 0) begin rd = {8'h00, q.pop_front()}; dec = sy ? 1 : 0; end
      else rd = 16'h0000;
    end else if (peek_rd) begin
      rd = (q.size() > 0) ? {8'h00, q[0]} : 16'h0000;
    end
    if (dec > 0) begin
      cnt = (cnt > dec) ? cnt - dec : 0;
      if (cnt == 0) tc = 1;
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    mstep(q0, m_cnt0, m_tc0, m_rd0, 1'b0);
    mstep(q1, m_cnt1, m_tc1, m_rd1, 1'b1);
    @(negedge clk);
    chk(tag, "count",  32'(cnt_a), 32'(q0.size()));
    chk(tag, "rdata",  32'(rd_a),  32'(m_rd0));
    chk(tag, "tc",     32'(tc_a),  32'(m_tc0));
    chk(tag, "drq",    32'(drq_a), 32'(drq_model(q0.size(), m_tc0)));
    chk(tag, "swap_count", 32'(cnt_b), 32'(q1.size()));
    chk(tag, "swap_rdata", 32'(rd_b),  32'(m_rd1));
    chk(tag, "swap_tc",    32'(tc_b),  32'(m_tc1));
    chk(tag, "swap_drq",   32'(drq_b), 32'(drq_model(q1.size(), m_tc1)));
    cnt_load = 0; byte_wr = 0; byte_rd = 0; half_wr = 0; half_rd = 0; peek_rd = 0;
  endtask

  task automatic ld(input int v, input string tag);
    cnt_load = 1; cnt_value = CW'(v); step(tag);
  endtask
  task automatic bwr(input logic [7:0] d, input string tag);
    byte_wr = 1; byte_wdata = d; step(tag);
  endtask
  task automatic hwr(input logic [15:0] d, input string tag);
    half_wr = 1; half_wdata = d; step(tag);
  endtask
  task automatic brd(input string tag);
    byte_rd = 1; step(tag);
  endtask
  task automatic hrd(input string tag);
    half_rd = 1; step(tag);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count", 32'(cnt_a), 0);
    chk("R1", "drq",   32'(drq_a), 0);
    chk("R1", "tc",    32'(tc_a),  0);
    chk("R1", "rdata", 32'(rd_a),  0);
    rst_n = 1;
    step("R1");

    // R2 byte path, asynchronous: reads leave the counter alone
    dma_en = 1; dma_to_mem = 1;
    ld(40, "R7");
    bwr(8'h11, "R2"); bwr(8'h22, "R9"); bwr(8'h33, "R2");
    brd("R2"); brd("R2");
    // R5 halfword writes, R3 halfword read
    hwr(16'hB2A1, "R5"); hwr(16'hD4C3, "R5");
    hrd("R3"); hrd("R3"); hrd("R11");
    // fill to 15 then halfword write degrades (R6)
    for (int i = 0; i < 7; i++) hwr(16'h0101 * (i + 5), "R5");
    bwr(8'h7E, "R2");
    hwr(16'hEEF0, "R6");
    hwr(16'h1234, "R6");
    bwr(8'h99, "R2");
    // R12 peek leaves everything
    peek_rd = 1; step("R12");
    peek_rd = 1; step("R12");
    // R13: write beats read in the same cycle; full so nothing changes
    byte_wr = 1; byte_rd = 1; byte_wdata = 8'h5A; step("R13");
    byte_rd = 1; peek_rd = 1; step("R13");
    // drain down to one byte, then odd and empty halfword reads (R4)
    for (int i = 0; i < 7; i++) hrd("R3");
    hrd("R4"); hrd("R4"); brd("R2"); peek_rd = 1; step("R12");
    // counter at 1 forces a single byte (R6) and terminal count (R8)
    ld(1, "R7");
    hwr(16'hCAFE, "R6");
    hwr(16'hBEEF, "R8"); bwr(8'h44, "R8");
    // R9 residual byte and synchronous stop after terminal count
    save_residual = 1;
    brd("R9"); brd("R9"); brd("R9"); brd("R9");
    bwr(8'h10, "R9"); bwr(8'h20, "R9");
    sync_offset = 5'd4; step("R9");
    ld(3, "R7"); step("R9");
    brd("R7"); brd("R7"); step("R8");
    save_residual = 0; step("R9");
    // R10 memory-to-device and disabled
    dma_to_mem = 0; step("R10");
    ld(50, "R10");
    for (int i = 0; i < 9; i++) hwr(16'h0202 * i, "R10");
    dma_en = 0; step("R10");
    dma_en = 1; sync_offset = 0;
    for (int i = 0; i < 9; i++) hrd("R3");

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      if (i % 50 == 0) begin
        dma_to_mem = $urandom_range(0, 1);
        save_residual = $urandom_range(0, 1);
        sync_offset = ($urandom_range(0, 1) != 0) ? 5'd3 : 5'd0;
      end
      if (r < 4) begin cnt_load = 1; cnt_value = CW'($urandom_range(0, 12)); end
      else if (r < 30) begin half_wr = 1; half_wdata = 16'($urandom); end
      else if (r < 50) begin byte_wr = 1; byte_wdata = 8'($urandom); end
      else if (r < 70) half_rd = 1;
      else if (r < 88) byte_rd = 1;
      else if (r < 94) peek_rd = 1;
      else begin byte_wr = 1; half_rd = 1; byte_wdata = 8'($urandom); end
      step("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule